// File: doc/BRIEF.md
# PWM Pulse Period and Duty Checker

This block watches a single pulse-width-modulated line and times every complete pulse cycle in system clocks. A cycle runs from one entry into the active level to the next. The active level is high by default and low when the invert control is set. When a cycle closes, the block reports the cycle length and the number of clocks spent at the active level. It also reports the invert setting and two mismatch flags, one for the period and one for the active time, each taken against expected values supplied on input ports.

The line may start at an arbitrary moment, so the first cycles after a reset or a clear are not reliable. The block therefore drops the first two measured cycles without reporting them. Four saturating counters cover the cycles that are kept: a total count, a pass count, a fail count, and a low-power count. The low-power count grows only when a low-power status input is high on the clock that closes the cycle.

At the end of a run, the surrounding logic pulses a run-done input. If the low-power count is still zero at that moment, a sticky status flag is raised. A synchronous clear restarts the measurement and empties every counter and the flag.

Top module: `pwm_pulse_meter`

## Requirements
- R1: After reset, and on the clock after `clr` is sampled high, all four counters read zero, `lp_none_err` is low and `meas_valid` is low.
- R2: The active level is `pwm_in` when `invert` is 0 and the complement of `pwm_in` when `invert` is 1. A cycle is delimited by two successive entries into the active level. `meas_valid` is a one-clock pulse and is never high on two consecutive clocks.
- R3: `meas_period` equals the number of clocks between the two delimiting entries. `meas_active` equals the number of those clocks that were spent at the active level.
- R4: `meas_invert` reports the `invert` setting that was in force when the cycle closed.
- R5: The first two measured cycles after reset or clear produce no `meas_valid` pulse and change no counter.
- R6: `period_err` is 1 exactly when `meas_period` differs from `exp_period`. `active_err` is 1 exactly when `meas_active` differs from `exp_active`. Each reported cycle adds one to `cnt_total`. It also adds one to `cnt_pass` when both flags are 0, or one to `cnt_fail` otherwise.
- R7: A reported cycle adds one to `cnt_lowpwr` when `low_power` was high on the clock on which the closing active entry was seen.
- R8: A `run_done` pulse while `cnt_lowpwr` is zero sets `lp_none_err`, which then stays high until `clr`. A `run_done` pulse while `cnt_lowpwr` is nonzero leaves it low.
- R9: Each counter stops at 2^STAT_W-1 instead of wrapping.
- R10: `meas_period` and `meas_active` stop at 2^CNT_W-1 for cycles longer than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters, status and measurement state |
| pwm_in | input | 1 | Observed pulse line, synchronous to clk |
| invert | input | 1 | 1 selects low as the active level |
| low_power | input | 1 | Low-power status of the system |
| exp_period | input | CNT_W | Expected cycle length in clocks |
| exp_active | input | CNT_W | Expected active time in clocks |
| run_done | input | 1 | End-of-run pulse that triggers the low-power check |
| meas_valid | output | 1 | One-clock strobe for a reported cycle |
| meas_period | output | CNT_W | Measured cycle length |
| meas_active | output | CNT_W | Measured active time |
| meas_invert | output | 1 | Invert setting for the reported cycle |
| period_err | output | 1 | Period mismatch for the reported cycle |
| active_err | output | 1 | Active-time mismatch for the reported cycle |
| cnt_total | output | STAT_W | Reported cycles |
| cnt_pass | output | STAT_W | Reported cycles with no mismatch |
| cnt_fail | output | STAT_W | Reported cycles with any mismatch |
| cnt_lowpwr | output | STAT_W | Reported cycles closed during low power |
| lp_none_err | output | 1 | Sticky: the run ended with no low-power cycle |

## Verification
A discard counter stuck at the wrong value shows up as an extra strobe, or a missing one, on the third cycle after a clear. That is at most one pulse cycle plus two clocks after the fault. A period or active-time counter that drifts by one makes the reported value differ from the scoreboard on the very next strobe, and the pass or fail counter moves the wrong way at the same moment. A counter that wraps instead of holding, or a low-power count that lands on the wrong cycle, appears in the counter comparison made at the end of each stimulus sequence. A status flag that fails to stick appears on the clock after `run_done`.

// File: rtl/pwm_meter_pkg.sv
package pwm_meter_pkg;
    localparam int NUM_CTRS   = 4;
    localparam int IDX_TOTAL  = 0;
    localparam int IDX_PASS   = 1;
    localparam int IDX_FAIL   = 2;
    localparam int IDX_LOWPWR = 3;
endpackage

// File: rtl/pwm_level_track.sv
// Registers the active level and marks the clock on which it is entered.
module pwm_level_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic invert,
    output logic act,
    output logic rise
);
    typedef struct packed {
        logic lvl;
        logic prev;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d.lvl  = pwm_in ^ invert;
        trk_d.prev = trk_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign act  = trk_q.lvl;
    assign rise = trk_q.lvl & ~trk_q.prev;
endmodule

// File: rtl/pwm_cycle_meas.sv
// Times each cycle between active entries, drops the first SKIP cycles,
// and emits one record per kept cycle.
module pwm_cycle_meas #(
    parameter int CNT_W = 16,
    parameter int SKIP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             act,
    input  logic             rise,
    input  logic             invert,
    input  logic             low_power,
    input  logic [CNT_W-1:0] exp_period,
    input  logic [CNT_W-1:0] exp_active,
    output logic             rec_vld,
    output logic [CNT_W-1:0] rec_period,
    output logic [CNT_W-1:0] rec_active,
    output logic             rec_inv,
    output logic             rec_perr,
    output logic             rec_aerr,
    output logic             rec_lp
);
    localparam int               SKIP_W = (SKIP > 0) ? $clog2(SKIP + 1) : 1;
    localparam logic [SKIP_W-1:0] SKIP_V = SKIP_W'(SKIP);
    localparam logic [CNT_W-1:0] CMAX   = '1;

    typedef struct packed {
        logic              started;
        logic [SKIP_W-1:0] skip;
        logic [CNT_W-1:0]  per;
        logic [CNT_W-1:0]  actc;
        logic              vld;
        logic [CNT_W-1:0]  o_per;
        logic [CNT_W-1:0]  o_act;
        logic              o_inv;
        logic              o_perr;
        logic              o_aerr;
        logic              o_lp;
    } meas_t;

    meas_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr) begin
            st_d.started = 1'b0;
            st_d.skip    = '0;
            st_d.per     = '0;
            st_d.actc    = '0;
        end else if (rise) begin
            if (st_q.started) begin
                if (st_q.skip == SKIP_V) begin
                    st_d.vld    = 1'b1;
                    st_d.o_per  = st_q.per;
                    st_d.o_act  = st_q.actc;
                    st_d.o_inv  = invert;
                    st_d.o_perr = (st_q.per != exp_period);
                    st_d.o_aerr = (st_q.actc != exp_active);
                    st_d.o_lp   = low_power;
                end else begin
                    st_d.skip = st_q.skip + 1'b1;
                end
            end
            st_d.started = 1'b1;
            st_d.per     = CNT_W'(1);
            st_d.actc    = CNT_W'(1);
        end else begin
            if (st_q.per != CMAX)          st_d.per  = st_q.per + 1'b1;
            if (act && st_q.actc != CMAX)  st_d.actc = st_q.actc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rec_vld    = st_q.vld;
    assign rec_period = st_q.o_per;
    assign rec_active = st_q.o_act;
    assign rec_inv    = st_q.o_inv;
    assign rec_perr   = st_q.o_perr;
    assign rec_aerr   = st_q.o_aerr;
    assign rec_lp     = st_q.o_lp;
endmodule

// File: rtl/pwm_sat_ctr.sv
// Saturating event counter with synchronous clear.
module pwm_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] VMAX = '1;

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (clr)                        val_d = '0;
        else if (inc && val_q != VMAX)  val_d = val_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;
endmodule

// File: rtl/pwm_pulse_meter.sv
module pwm_pulse_meter
    import pwm_meter_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STAT_W = 16,
    parameter int SKIP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pwm_in,
    input  logic              invert,
    input  logic              low_power,
    input  logic [CNT_W-1:0]  exp_period,
    input  logic [CNT_W-1:0]  exp_active,
    input  logic              run_done,
    output logic              meas_valid,
    output logic [CNT_W-1:0]  meas_period,
    output logic [CNT_W-1:0]  meas_active,
    output logic              meas_invert,
    output logic              period_err,
    output logic              active_err,
    output logic [STAT_W-1:0] cnt_total,
    output logic [STAT_W-1:0] cnt_pass,
    output logic [STAT_W-1:0] cnt_fail,
    output logic [STAT_W-1:0] cnt_lowpwr,
    output logic              lp_none_err
);
    logic act, rise;
    logic rec_vld, rec_inv, rec_perr, rec_aerr, rec_lp;
    logic [CNT_W-1:0] rec_period, rec_active;

    pwm_level_track u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm_in (pwm_in),
        .invert (invert),
        .act    (act),
        .rise   (rise)
    );

    pwm_cycle_meas #(.CNT_W(CNT_W), .SKIP(SKIP)) u_meas (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .act        (act),
        .rise       (rise),
        .invert     (invert),
        .low_power  (low_power),
        .exp_period (exp_period),
        .exp_active (exp_active),
        .rec_vld    (rec_vld),
        .rec_period (rec_period),
        .rec_active (rec_active),
        .rec_inv    (rec_inv),
        .rec_perr   (rec_perr),
        .rec_aerr   (rec_aerr),
        .rec_lp     (rec_lp)
    );

    logic [NUM_CTRS-1:0] bump;
    logic [STAT_W-1:0]   ctr_val [NUM_CTRS];

    always_comb begin
        bump             = '0;
        bump[IDX_TOTAL]  = rec_vld;
        bump[IDX_PASS]   = rec_vld & ~rec_perr & ~rec_aerr;
        bump[IDX_FAIL]   = rec_vld & (rec_perr | rec_aerr);
        bump[IDX_LOWPWR] = rec_vld & rec_lp;
    end

    for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
        pwm_sat_ctr #(.W(STAT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (bump[g]),
            .value (ctr_val[g])
        );
    end

    logic lpz_d, lpz_q;

    always_comb begin
        lpz_d = lpz_q;
        if (clr)                                         lpz_d = 1'b0;
        else if (run_done && ctr_val[IDX_LOWPWR] == '0)  lpz_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lpz_q <= 1'b0;
        else        lpz_q <= lpz_d;
    end

    assign meas_valid  = rec_vld;
    assign meas_period = rec_period;
    assign meas_active = rec_active;
    assign meas_invert = rec_inv;
    assign period_err  = rec_perr;
    assign active_err  = rec_aerr;
    assign cnt_total   = ctr_val[IDX_TOTAL];
    assign cnt_pass    = ctr_val[IDX_PASS];
    assign cnt_fail    = ctr_val[IDX_FAIL];
    assign cnt_lowpwr  = ctr_val[IDX_LOWPWR];
    assign lp_none_err = lpz_q;
endmodule

// File: rtl/pwm_pulse_meter_chk.sv
module pwm_pulse_meter_chk #(
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              meas_valid,
    input logic [STAT_W-1:0] cnt_total,
    input logic [STAT_W-1:0] cnt_pass,
    input logic [STAT_W-1:0] cnt_fail,
    input logic [STAT_W-1:0] cnt_lowpwr,
    input logic              lp_none_err
);
    localparam logic [STAT_W-1:0] SMAX = '1;

    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_total == '0 && cnt_pass == '0 && cnt_fail == '0 &&
                 cnt_lowpwr == '0 && !lp_none_err && !meas_valid));

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);

    a_r6_split_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_total != SMAX) |->
        ({1'b0, cnt_pass} + {1'b0, cnt_fail} == {1'b0, cnt_total}));

    a_r7_lp_subset: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_lowpwr <= cnt_total);

    a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_none_err && !clr) |=> lp_none_err);

    a_r9_step_or_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_total == $past(cnt_total) ||
                  {1'b0, cnt_total} == {1'b0, $past(cnt_total)} + 1'b1));
endmodule

bind pwm_pulse_meter pwm_pulse_meter_chk #(.STAT_W(STAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .meas_valid  (meas_valid),
    .cnt_total   (cnt_total),
    .cnt_pass    (cnt_pass),
    .cnt_fail    (cnt_fail),
    .cnt_lowpwr  (cnt_lowpwr),
    .lp_none_err (lp_none_err)
);

// File: tb/tb_pwm_pulse_meter.sv
`timescale 1ns/1ps
module tb_pwm_pulse_meter;
    localparam int CW   = 8;
    localparam int SW   = 4;
    localparam int CMAX = (1 << CW) - 1;
    localparam int SMAX = (1 << SW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic pwm_in = 1'b0;
    logic invert = 1'b0;
    logic low_power = 1'b0;
    logic [CW-1:0] exp_period = '0;
    logic [CW-1:0] exp_active = '0;
    logic run_done = 1'b0;
    logic meas_valid, meas_invert, period_err, active_err, lp_none_err;
    logic [CW-1:0] meas_period, meas_active;
    logic [SW-1:0] cnt_total, cnt_pass, cnt_fail, cnt_lowpwr;

    always #2.5 clk = ~clk;

    pwm_pulse_meter #(.CNT_W(CW), .STAT_W(SW), .SKIP(2)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pwm_in(pwm_in), .invert(invert),
        .low_power(low_power), .exp_period(exp_period), .exp_active(exp_active),
        .run_done(run_done), .meas_valid(meas_valid), .meas_period(meas_period),
        .meas_active(meas_active), .meas_invert(meas_invert),
        .period_err(period_err), .active_err(active_err),
        .cnt_total(cnt_total), .cnt_pass(cnt_pass), .cnt_fail(cnt_fail),
        .cnt_lowpwr(cnt_lowpwr), .lp_none_err(lp_none_err)
    );

    typedef struct {
        int per;
        int act;
        bit inv;
        bit perr;
        bit aerr;
    } exp_t;

    exp_t sbq[$];
    int errors = 0;
    int checks = 0;
    int e_total, e_pass, e_fail, e_lp;
    int cyc_idx, prev_h, prev_l;
    bit inv_cur, lp_cur;
    int ep_cur, ea_cur;

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, want);
        end
    endtask

    function automatic int sat_inc(input int v);
        return (v < SMAX) ? v + 1 : v;
    endfunction

    // Scoreboard monitor: compares every strobe with the queue head
    always @(negedge clk) begin
        if (rst_n && meas_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R5", "unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(meas_period == e.per, "R3/R10", "period", int'(meas_period), e.per);
                chk(meas_active == e.act, "R3/R10", "active", int'(meas_active), e.act);
                chk(meas_invert == e.inv, "R4", "invert", int'(meas_invert), int'(e.inv));
                chk(period_err == e.perr, "R6", "period_err", int'(period_err), int'(e.perr));
                chk(active_err == e.aerr, "R6", "active_err", int'(active_err), int'(e.aerr));
            end
        end
    end

    task automatic start_seq(input bit inv, input bit lp, input int ep, input int ea);
        @(negedge clk);
        invert = inv; pwm_in = inv; low_power = lp;
        exp_period = CW'(ep); exp_active = CW'(ea);
        inv_cur = inv; lp_cur = lp; ep_cur = ep; ea_cur = ea;
        clr = 1'b1;
        repeat (3) @(negedge clk);
        clr = 1'b0;
        chk(cnt_total == 0 && cnt_pass == 0 && cnt_fail == 0 && cnt_lowpwr == 0,
            "R1", "counters after clear", int'(cnt_total), 0);
        chk(lp_none_err == 1'b0, "R1", "status after clear", int'(lp_none_err), 0);
        e_total = 0; e_pass = 0; e_fail = 0; e_lp = 0; cyc_idx = 0;
    endtask

    // One pulse cycle: h clocks active then l clocks idle
    task automatic gen_cycle(input int h, input int l);
        if (cyc_idx >= 3) begin
            exp_t e;
            e.per  = (prev_h + prev_l > CMAX) ? CMAX : prev_h + prev_l;
            e.act  = (prev_h > CMAX) ? CMAX : prev_h;
            e.inv  = inv_cur;
            e.perr = (e.per != ep_cur);
            e.aerr = (e.act != ea_cur);
            sbq.push_back(e);
            e_total = sat_inc(e_total);
            if (!e.perr && !e.aerr) e_pass = sat_inc(e_pass);
            else                    e_fail = sat_inc(e_fail);
            if (lp_cur) e_lp = sat_inc(e_lp);
        end
        for (int i = 0; i < h; i++) begin
            @(negedge clk);
            pwm_in = ~inv_cur;
        end
        for (int i = 0; i < l; i++) begin
            @(negedge clk);
            pwm_in = inv_cur;
        end
        prev_h = h; prev_l = l;
        cyc_idx++;
    endtask

    task automatic end_seq(input string tag);
        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R5", {tag, " missing strobes"}, sbq.size(), 0);
        sbq.delete();
        chk(cnt_total == e_total, "R6/R9", {tag, " cnt_total"}, int'(cnt_total), e_total);
        chk(cnt_pass == e_pass, "R6/R9", {tag, " cnt_pass"}, int'(cnt_pass), e_pass);
        chk(cnt_fail == e_fail, "R6", {tag, " cnt_fail"}, int'(cnt_fail), e_fail);
        chk(cnt_lowpwr == e_lp, "R7/R9", {tag, " cnt_lowpwr"}, int'(cnt_lowpwr), e_lp);
    endtask

    task automatic pulse_done(input bit want, input string tag);
        @(negedge clk);
        run_done = 1'b1;
        @(negedge clk);
        run_done = 1'b0;
        chk(lp_none_err == want, "R8", tag, int'(lp_none_err), int'(want));
        repeat (2) @(negedge clk);
        chk(lp_none_err == want, "R8", {tag, " held"}, int'(lp_none_err), int'(want));
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(meas_valid == 0 && cnt_total == 0 && cnt_pass == 0 && cnt_fail == 0 &&
            cnt_lowpwr == 0 && lp_none_err == 0, "R1", "reset state", int'(cnt_total), 0);
        rst_n = 1'b1;

        // R5: only two measured cycles, both dropped
        start_seq(1'b0, 1'b0, 10, 4);
        gen_cycle(4, 6); gen_cycle(4, 6); gen_cycle(4, 6);
        end_seq("R5 discard");

        // R2/R3: non-inverted, all matching
        start_seq(1'b0, 1'b0, 12, 5);
        for (int k = 0; k < 6; k++) gen_cycle(5, 7);
        end_seq("R3 plain");
        pulse_done(1'b1, "R8 no low-power cycles");

        // R2/R4/R6/R7: inverted, low power, mixed mismatches
        start_seq(1'b1, 1'b1, 12, 4);
        gen_cycle(4, 8); gen_cycle(4, 8); gen_cycle(4, 8); gen_cycle(6, 6);
        gen_cycle(4, 9); gen_cycle(3, 9); gen_cycle(4, 8); gen_cycle(2, 2);
        end_seq("R2 inverted");
        pulse_done(1'b0, "R8 low-power seen");

        // R9: counter saturation
        start_seq(1'b0, 1'b1, 6, 3);
        for (int k = 0; k < 20; k++) gen_cycle(3, 3);
        end_seq("R9 saturate");
        chk(cnt_total == SMAX, "R9", "total held at max", int'(cnt_total), SMAX);

        // R10: measurement saturation
        start_seq(1'b0, 1'b0, 255, 200);
        gen_cycle(200, 100); gen_cycle(200, 100); gen_cycle(200, 100);
        gen_cycle(270, 10); gen_cycle(2, 2);
        end_seq("R10 long");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule